// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the management side of a two-wire PHY control link. A host hands it one request at a time. Each request is a read or a write and carries a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit data word. The block then builds the whole serial frame itself. It derives the management clock from the system clock and sends a long run of ones, the start and operation fields, both address fields, a turnaround and the 16-bit data phase. It finishes with a few closing clocks. The line is driven through separate output-data and output-enable signals and is sampled on a separate input.

A read returns its 16-bit result with a one-cycle completion pulse. The PHY must pull the read turnaround bit low. If it leaves the line high, the block does not take data. It clocks a fixed run of recovery cycles with the line released and then raises an error flag. Result and flag stay valid until the next request is accepted.

The management clock idles high. Each of its half-periods lasts `HALF_CLKS` system clocks, with a minimum of 2. Every frame bit takes one full management clock period, which is called a slot below. The slot starts with the low half, and the line may change only in that half. The high half follows, and the line holds steady through it.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is running, `mdc` is 1, `mdio_oe` is 0, `req_ready` is 1, `done` is 0 and `err` is 0.
- R2: Every frame opens with 32 slots (slots 0..31) in which `mdio_oe`=1 and `mdio_o`=1.
- R3: Slots 32 and 33 carry 0 then 1. Slots 34 and 35 carry the operation: 1,0 for a read (`req_write`=0) and 0,1 for a write (`req_write`=1).
- R4: Slots 36..40 carry `req_phy` bit 4 down to bit 0. Slots 41..45 carry `req_reg` bit 4 down to bit 0, all driven.
- R5: Each half-period of `mdc` lasts `HALF_CLKS` system clocks. While a frame runs, `mdio_o` and `mdio_oe` change only in a system clock where `mdc` is low.
- R6: A write drives 1 then 0 in slots 46 and 47, then `req_wdata` bit 15 down to bit 0 in slots 48..63. Slot 64 is released (`mdio_oe`=0), and the frame has exactly 65 slots.
- R7: A read releases the line from slot 46 on. The bit `mdio_i` holds at the end of the high half of slot 46 is the turnaround. If it is 0, bits 15..0 of `rd_data` are taken at the end of the high halves of slots 47..62. Two released slots follow, for 65 slots in all, and `err` stays 0.
- R8: If the read turnaround sample is 1, the block runs 32 more released slots (79 in all). It then finishes with `err`=1 and `rd_data`=0.
- R9: A request is accepted only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 during a frame, and a request made then is ignored. `done` is high for exactly one cycle per frame. Acceptance clears `rd_data` and `err`, and both then hold until the next acceptance.
- R10: A synchronous reset in the middle of a frame brings back the idle state of R1 on the next cycle and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line value to drive |
| mdio_oe | output | 1 | Line drive enable |
| mdio_i | input | 1 | Sampled line value |
| done | output | 1 | One-cycle frame completion pulse |
| rd_data | output | 16 | Read result, held |
| err | output | 1 | Turnaround error, held |

## Verification
The assertions assume that `mdio_i` is synchronous to `clk` and steady through the high half of each slot. They also assume that the request fields are steady in the cycle `req_valid` is taken and that `HALF_CLKS` is at least 2. The bench's PHY model changes `mdio_i` half a system clock after each `mdc` rise and holds it until the next rise, so each sample lands well inside a stable window. Requests are driven on falling clock edges. The one request made during a busy frame comes well inside the preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_PRE, PH_HDR, PH_WTA, PH_WDAT, PH_WREL,
    PH_RTA, PH_RDAT, PH_RTAIL, PH_RECOV
  } mdio_phase_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] SOF   = 2'b01;
endpackage

// File: rtl/mdio_halfclk.sv
module mdio_halfclk #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNTW = $clog2(HALF_CLKS);
  localparam logic [CNTW-1:0] LAST = CNTW'(HALF_CLKS - 1);

  if (HALF_CLKS < 2) begin : g_bad_half
    $error("HALF_CLKS must be at least 2");
  end

  logic [CNTW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);  // R5
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int REC_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          st_write,
  input  logic [AW-1:0] st_phy,
  input  logic [AW-1:0] st_reg,
  input  logic [DW-1:0] st_wdata,
  input  logic          tick,
  input  logic          mdio_i,
  output logic          busy,
  output logic          mdc,
  output logic          mdio_oe,
  output logic          mdio_o,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          err
);
  localparam int HW   = 4 + 2 * AW;
  localparam int M1   = (PRE_LEN > REC_LEN) ? PRE_LEN : REC_LEN;
  localparam int M2   = (DW > HW) ? DW : HW;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_LEN - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_LEN - 1);
  localparam logic [CW-1:0] HDR_LAST = CW'(HW - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  mdio_phase_e   phase;
  logic [CW-1:0] bcnt;
  logic          hi, wr;
  logic [HW-1:0] hdr_sh;
  logic [DW-1:0] wr_sh, rd_sh;

  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bcnt    <= '0;
      hi      <= 1'b0;
      wr      <= 1'b0;
      mdc     <= 1'b1;
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
      hdr_sh  <= '0;
      wr_sh   <= '0;
      rd_sh   <= '0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase   <= PH_PRE;
          bcnt    <= '0;
          hi      <= 1'b0;
          mdc     <= 1'b0;
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b1;
          hdr_sh  <= {SOF, (st_write ? OP_WR : OP_RD), st_phy, st_reg};
          wr_sh   <= st_wdata;
          wr      <= st_write;
          err     <= 1'b0;
          rd_data <= '0;
        end
      end else if (tick && !hi) begin
        hi  <= 1'b1;
        mdc <= 1'b1;
      end else if (tick && hi) begin
        hi   <= 1'b0;
        mdc  <= 1'b0;
        bcnt <= bcnt + 1'b1;
        unique case (phase)
          PH_PRE: if (bcnt == PRE_LAST) begin
            phase  <= PH_HDR;
            bcnt   <= '0;
            mdio_o <= hdr_sh[HW-1];
            hdr_sh <= hdr_sh << 1;
          end
          PH_HDR: if (bcnt == HDR_LAST) begin
            bcnt <= '0;
            if (wr) begin
              phase  <= PH_WTA;
              mdio_o <= 1'b1;
            end else begin
              phase   <= PH_RTA;
              mdio_oe <= 1'b0;
            end
          end else begin
            mdio_o <= hdr_sh[HW-1];
            hdr_sh <= hdr_sh << 1;
          end
          PH_WTA: if (bcnt == '0) begin
            mdio_o <= 1'b0;
          end else begin
            phase  <= PH_WDAT;
            bcnt   <= '0;
            mdio_o <= wr_sh[DW-1];
            wr_sh  <= wr_sh << 1;
          end
          PH_WDAT: if (bcnt == DAT_LAST) begin
            phase   <= PH_WREL;
            bcnt    <= '0;
            mdio_oe <= 1'b0;
          end else begin
            mdio_o <= wr_sh[DW-1];
            wr_sh  <= wr_sh << 1;
          end
          PH_WREL: begin
            phase <= PH_IDLE;
            mdc   <= 1'b1;
            done  <= 1'b1;
          end
          PH_RTA: begin
            bcnt  <= '0;
            phase <= mdio_i ? PH_RECOV : PH_RDAT;
          end
          PH_RDAT: begin
            rd_sh <= {rd_sh[DW-2:0], mdio_i};
            if (bcnt == DAT_LAST) begin
              phase <= PH_RTAIL;
              bcnt  <= '0;
            end
          end
          PH_RTAIL: if (bcnt == ONE) begin
            phase   <= PH_IDLE;
            mdc     <= 1'b1;
            done    <= 1'b1;
            rd_data <= rd_sh;
          end
          PH_RECOV: if (bcnt == REC_LAST) begin
            phase <= PH_IDLE;
            mdc   <= 1'b1;
            done  <= 1'b1;
            err   <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));  // R1
  AST_PRE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRE) |-> (mdio_oe && mdio_o));  // R2
  AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (done && !busy));  // R8
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CLKS = 4,
  parameter int PRE_LEN   = 32,
  parameter int REC_LEN   = 32,
  parameter int AW        = 5,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_phy,
  input  logic [AW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          err
);
  logic busy, tick;

  assign req_ready = !busy;

  mdio_halfclk #(.HALF_CLKS(HALF_CLKS)) u_half (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (tick)
  );

  mdio_seq #(
    .PRE_LEN(PRE_LEN), .REC_LEN(REC_LEN), .AW(AW), .DW(DW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (req_valid && req_ready),
    .st_write (req_write),
    .st_phy   (req_phy),
    .st_reg   (req_reg),
    .st_wdata (req_wdata),
    .tick     (tick),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .mdio_o   (mdio_o),
    .done     (done),
    .rd_data  (rd_data),
    .err      (err)
  );
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int HALF = 4;
  localparam int NV   = 5;
  // {write, phy[4:0], reg[4:0], wdata[15:0], ta, rdata[15:0]}
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b0, 16'h0000},
    {1'b1, 5'h1F, 5'h1F, 16'h8001, 1'b0, 16'h0000},
    {1'b0, 5'h10, 5'h01, 16'h0000, 1'b0, 16'h1234},
    {1'b0, 5'h00, 5'h1E, 16'h0000, 1'b0, 16'hFFFE},
    {1'b0, 5'h0A, 5'h15, 16'h0000, 1'b1, 16'hBEEF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic mdio_i = 1'b1;
  logic req_ready, mdc, mdio_o, mdio_oe, done, err;
  logic [15:0] rd_data;

  int total = 0, bad = 0, cyc = 0;
  int nslot = 0, done_cnt = 0, per_bad = 0, stab_bad = 0, last_rise = 0;
  logic mdc_q = 1'b1, oe_q = 1'b0, o_q = 1'b0;
  logic rec_oe [96], rec_o [96], exp_oe [96], exp_o [96];
  logic ph_ta = 1'b0;
  logic [15:0] ph_data = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_master #(.HALF_CLKS(HALF)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .done(done), .rd_data(rd_data), .err(err)
  );

  // PHY model and line monitor, away from the active edge
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mdc === 1'b1 && mdc_q === 1'b0) begin
      if (nslot < 96) begin
        rec_oe[nslot] = mdio_oe;
        rec_o[nslot]  = mdio_o;
      end
      if (nslot > 0 && (cyc - last_rise) != 2 * HALF) per_bad++;
      last_rise = cyc;
      if (nslot == 46) mdio_i <= ph_ta;
      else if (nslot >= 47 && nslot <= 62) mdio_i <= ph_data[62 - nslot];
      else mdio_i <= 1'b1;
      nslot++;
    end else if (mdc === 1'b1 && mdc_q === 1'b1 && req_ready === 1'b0 &&
                 (mdio_oe !== oe_q || mdio_o !== o_q)) begin
      stab_bad++;
    end
    mdc_q = mdc;
    oe_q  = mdio_oe;
    o_q   = mdio_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_slots(input int lo, input int hi, input string tag);
    int mism = -1;
    for (int s = lo; s <= hi; s++)
      if (mism < 0 && (rec_oe[s] !== exp_oe[s] || (exp_oe[s] && rec_o[s] !== exp_o[s])))
        mism = s;
    if (mism < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, {rec_oe[mism], rec_o[mism]}, {exp_oe[mism], exp_o[mism]});
  endtask

  task automatic run_frame(input logic [43:0] v);
    logic w = v[43];
    logic [4:0] phy = v[42:38];
    logic [4:0] rg = v[37:33];
    logic [15:0] wd = v[32:17];
    logic ta = v[16];
    logic [15:0] rdd = v[15:0];
    int n = w ? 65 : (ta ? 79 : 65);
    bit seen = 0;
    for (int s = 0; s < 96; s++) begin exp_oe[s] = 1'b0; exp_o[s] = 1'b0; end
    for (int s = 0; s < 46; s++) exp_oe[s] = 1'b1;
    for (int s = 0; s < 32; s++) exp_o[s] = 1'b1;
    exp_o[33] = 1'b1;
    exp_o[34] = !w; exp_o[35] = w;
    for (int b = 0; b < 5; b++) begin
      exp_o[36 + b] = phy[4 - b];
      exp_o[41 + b] = rg[4 - b];
    end
    if (w) begin
      exp_oe[46] = 1'b1; exp_o[46] = 1'b1; exp_oe[47] = 1'b1;
      for (int b = 0; b < 16; b++) begin
        exp_oe[48 + b] = 1'b1;
        exp_o[48 + b]  = wd[15 - b];
      end
    end
    ph_ta = ta; ph_data = rdd;
    nslot = 0; done_cnt = 0; per_bad = 0; stab_bad = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = w; req_phy = phy; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R9 done timeout", 0, 1);
    if (w || !ta) begin
      check(err == 1'b0, w ? "R6 err" : "R7 err", err, 0);
      check(rd_data == (w ? 16'h0 : rdd), w ? "R9 rd_data cleared" : "R7 rd_data", rd_data, w ? 0 : rdd);
    end else begin
      check(err == 1'b1, "R8 err", err, 1);
      check(rd_data == 16'h0, "R8 rd_data", rd_data, 0);
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R9 done width", done_cnt, 1);
    check(nslot == n, w ? "R6 slots" : (ta ? "R8 slots" : "R7 slots"), nslot, n);
    check(per_bad == 0, "R5 period", per_bad, 0);
    check(stab_bad == 0, "R5 stable high", stab_bad, 0);
    chk_slots(0, 31, "R2 preamble");
    chk_slots(32, 35, "R3 start/op");
    chk_slots(36, 45, "R4 addresses");
    chk_slots(46, n - 1, w ? "R6 tail" : (ta ? "R8 tail" : "R7 tail"));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mdc == 1'b1, "R1 mdc idle", mdc, 1);
    check(mdio_oe == 1'b0, "R1 oe idle", mdio_oe, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(err == 1'b0 && done == 1'b0, "R1 err/done", {err, done}, 0);

    for (int k = 0; k < NV; k++) run_frame(VEC[k]);

    // R9 error and empty data held until next request
    repeat (20) @(negedge clk);
    check(err == 1'b1 && rd_data == 16'h0, "R9 hold", {err, rd_data}, 17'h10000);

    // R10 reset clears err
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(err == 1'b0, "R10 err cleared", err, 0);

    // R9 request during busy frame is ignored
    fork
      run_frame(VEC[0]);
      begin
        repeat (60) @(negedge clk);
        req_write = 1'b0; req_phy = 5'h15; req_reg = 5'h0A; req_valid = 1'b1;
        check(req_ready == 1'b0, "R9 ready busy", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
      end
    join

    // R10 reset mid-frame
    req_write = 1'b1; req_phy = 5'h03; req_reg = 5'h04; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(mdc == 1'b1 && mdio_oe == 1'b0, "R10 lines idle", {mdc, mdio_oe}, 2);
    check(req_ready == 1'b1 && err == 1'b0, "R10 ready", {req_ready, err}, 2);
    repeat (5) @(negedge clk);
    run_frame(VEC[2]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule